// File: doc/BRIEF.md
# Raster Timing and Border Generator

This block produces the raster timing for a video output. It runs a horizontal counter over the clocks of each line and a vertical counter over the lines of each field. From their positions it derives the sync pulses, a programmable border region, and the display window that sits inside the border. For interlaced scanning it supplies a field indicator, and it produces a one-clock vertical blanking pulse that can drive an interrupt.

Software programs eight registers through a simple write port. Every write lands in a shadow copy. While the display is disabled, the active set follows the shadow set on every clock. While the display is running, the active set takes the shadow contents only in the vertical blanking pulse cycle, so a mode change never tears a frame.

The block supports line doubling, where each scan line is output twice. It supports horizontal pixel doubling, shown by a pixel-advance strobe that fires every second clock. A blank control stretches the border over the whole visible area while the timing keeps running. Pixel fetch, the palette and analog encoding are handled elsewhere.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_ni` is low, all outputs are 0: both counters, all flags, `border_rgb_o` and `pix_clk_dbl_o`. All registers clear, so the display is disabled.
- R2: Register map (word address on `wr_addr_i`, fields are counter-width values at data bits [9:0] "lo" and [25:16] "hi"):
  - 0: sync size, with lo = horizontal total and hi = vertical total.
  - 1: horizontal border, with hi = start and lo = stop.
  - 2: vertical border, with hi = start and lo = stop.
  - 3: window start, with lo = horizontal and hi = vertical.
  - 4: mode, with bit 0 = display enable, bit 1 = line doubling and bit 23 = doubled pixel clock.
  - 5: window config, with bit 0 = pixel doubling and bit 3 = blank.
  - 6: sync config, with bit 8 = video enable and bit 4 = interlace.
  - 7: border colour, bits [23:0].

  A write goes to the shadow set. The active set loads the shadow set at the clock edge that ends a cycle in which the active display enable is 0 or `vblank_o` is 1, and at no other edge.
- R3: When enabled, `hcnt_o` counts 0 up to the horizontal total and then returns to 0, so a line lasts total+1 clocks.
- R4: `vcnt_o` advances at each line end and returns to 0 after its last line. `vblank_o` is 1 for exactly the cycle in which `hcnt_o`=0, `vcnt_o` equals the vertical border stop, `line_rep_o`=0 and the display is enabled.
- R5: With interlace off, `field_o` is 0 and a field has vertical total+1 lines. With interlace on, `field_o` toggles at each field wrap. Field 0 has vertical total+1 lines and field 1 has vertical total lines. `field_o` changes only on the edge into `hcnt_o`=`vcnt_o`=0.
- R6: With line doubling on, each value of `vcnt_o` lasts two lines, and `line_rep_o` is 1 during the second one.
- R7: `hsync_o` is 1 while `hcnt_o` < HSYNC_W, and `vsync_o` is 1 while `vcnt_o` < VSYNC_L, both only when output is enabled.
- R8: The visible region is h in [border h start, border h stop) and v in [border v start, border v stop). `window_o` marks the visible positions with h ≥ window h start and v ≥ window v start. `border_o` marks the other visible positions. The two are never 1 together.
- R9: With blank on, `window_o` is 0 and `border_o` is 1 over the whole visible region, while the counters keep running.
- R10: `pix_adv_o` is `window_o` when pixel doubling is off. When pixel doubling is on, it is `window_o` on clocks where (h − window h start) is even.
- R11: With display enable 0 the counters, field and repeat state are held at 0. Sync, border and window outputs need both display enable and video enable.
- R12: `border_rgb_o` and `pix_clk_dbl_o` show the active border colour and the active mode bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Register write data |
| hcnt_o | output | 10 | Horizontal counter |
| vcnt_o | output | 10 | Vertical counter |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| border_o | output | 1 | Border colour is shown |
| window_o | output | 1 | Display window is active |
| field_o | output | 1 | Current field (1 = short field) |
| line_rep_o | output | 1 | Second copy of a doubled line |
| pix_adv_o | output | 1 | Fetch the next pixel |
| vblank_o | output | 1 | One-clock vertical blanking pulse |
| border_rgb_o | output | 24 | Active border colour |
| pix_clk_dbl_o | output | 1 | Doubled pixel clock select |

## Verification
The counters and the active register set are the only timing state. Every flag is decoded from that state in the same cycle, so a counter step or a register transfer is visible in the cycle right after the edge that causes it. A register write is visible one edge after the transfer cycle that follows the write.

The bench drives its inputs and compares every output at the falling edge. It steps a reference model, kept apart from the design, at each rising edge. Writes made while the display runs are checked to stay hidden until the cycle after the vertical blanking pulse.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned CNT_W  = 10;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HI_LSB = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_SYNC = 3'd0, A_HBRD = 3'd1, A_VBRD = 3'd2, A_WIN = 3'd3,
    A_MODE = 3'd4, A_WCFG = 3'd5, A_SCFG = 3'd6, A_RGB = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [CNT_W-1:0] htot;
    logic [CNT_W-1:0] vtot;
    logic [CNT_W-1:0] bsh;
    logic [CNT_W-1:0] beh;
    logic [CNT_W-1:0] bsv;
    logic [CNT_W-1:0] bev;
    logic [CNT_W-1:0] wh;
    logic [CNT_W-1:0] wv;
    logic             en;
    logic             ldbl;
    logic             clkdbl;
    logic             pdbl;
    logic             blank;
    logic             vid;
    logic             il;
    logic [23:0]      rgb;
  } cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              xfer_i,
  output cfg_t              act_o
);
  cfg_t shd_q, act_q;
  logic [CNT_W-1:0] lo, hi;

  assign lo = wr_data_i[CNT_W-1:0];
  assign hi = wr_data_i[HI_LSB +: CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        A_SYNC: begin shd_q.htot <= lo; shd_q.vtot <= hi; end
        A_HBRD: begin shd_q.bsh  <= hi; shd_q.beh  <= lo; end
        A_VBRD: begin shd_q.bsv  <= hi; shd_q.bev  <= lo; end
        A_WIN:  begin shd_q.wh   <= lo; shd_q.wv   <= hi; end
        A_MODE: begin
          shd_q.en     <= wr_data_i[0];
          shd_q.ldbl   <= wr_data_i[1];
          shd_q.clkdbl <= wr_data_i[23];
        end
        A_WCFG: begin shd_q.pdbl <= wr_data_i[0]; shd_q.blank <= wr_data_i[3]; end
        A_SCFG: begin shd_q.vid  <= wr_data_i[8]; shd_q.il    <= wr_data_i[4]; end
        default: shd_q.rgb <= wr_data_i[23:0];
      endcase
    end
  end

  // active set moves only while stopped or at the vblank pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (xfer_i) act_q <= shd_q;
  end

  assign act_o = act_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(act_q));
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
  import rtg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  output logic [CNT_W-1:0] h_o,
  output logic [CNT_W-1:0] v_o,
  output logic             field_o,
  output logic             rep_o
);
  logic [CNT_W-1:0] h_q, v_q, last_v;
  logic             field_q, rep_q, line_end;

  assign line_end = (h_q == cfg_i.htot);
  // field 1 is the short field in interlaced scanning
  assign last_v   = (cfg_i.il && field_q) ? cfg_i.vtot - 1'b1 : cfg_i.vtot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0; v_q <= '0; field_q <= 1'b0; rep_q <= 1'b0;
    end else if (!cfg_i.en) begin
      h_q <= '0; v_q <= '0; field_q <= 1'b0; rep_q <= 1'b0;
    end else if (!line_end) begin
      h_q <= h_q + 1'b1;
    end else begin
      h_q <= '0;
      if (cfg_i.ldbl && !rep_q) begin
        rep_q <= 1'b1;
      end else begin
        rep_q <= 1'b0;
        if (v_q == last_v) begin
          v_q     <= '0;
          field_q <= cfg_i.il ? ~field_q : 1'b0;
        end else begin
          v_q <= v_q + 1'b1;
        end
      end
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;
  assign field_o = field_q;
  assign rep_o = rep_q;

  assert_hwrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && line_end) |=> (h_q == '0));

  assert_field_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && $past(cfg_i.en) && (field_q != $past(field_q)))
      |-> (h_q == '0 && v_q == '0 && !rep_q));

  assert_rep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && !cfg_i.ldbl) |-> !rep_q || (h_q == '0) || $past(rep_q));
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
#(
  parameter int unsigned HSYNC_W = 6,
  parameter int unsigned VSYNC_L = 2
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic [CNT_W-1:0] h_i,
  input  logic [CNT_W-1:0] v_i,
  input  logic             rep_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             border_o,
  output logic             window_o,
  output logic             pix_adv_o,
  output logic             vblank_o
);
  localparam logic [CNT_W-1:0] HS_END = CNT_W'(HSYNC_W);
  localparam logic [CNT_W-1:0] VS_END = CNT_W'(VSYNC_L);

  logic out_en, vis, in_win;
  logic [CNT_W-1:0] rel_h;

  assign out_en = cfg_i.en && cfg_i.vid;
  assign vis    = (h_i >= cfg_i.bsh) && (h_i < cfg_i.beh) &&
                  (v_i >= cfg_i.bsv) && (v_i < cfg_i.bev);
  assign in_win = vis && (h_i >= cfg_i.wh) && (v_i >= cfg_i.wv);
  assign rel_h  = h_i - cfg_i.wh;

  assign hsync_o   = out_en && (h_i < HS_END);
  assign vsync_o   = out_en && (v_i < VS_END);
  assign window_o  = out_en && in_win && !cfg_i.blank;
  assign border_o  = out_en && vis && (cfg_i.blank || !in_win);
  assign pix_adv_o = window_o && (!cfg_i.pdbl || !rel_h[0]);
  assign vblank_o  = cfg_i.en && (h_i == '0) && (v_i == cfg_i.bev) && !rep_i;

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(window_o && border_o));

  assert_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.blank |-> !window_o);

  assert_vblank_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vblank_o && cfg_i.htot != '0) |=> !vblank_o);

  assert_adv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_adv_o |-> window_o);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned HSYNC_W = 6,
  parameter int unsigned VSYNC_L = 2
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  hcnt_o,
  output logic [CNT_W-1:0]  vcnt_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              border_o,
  output logic              window_o,
  output logic              field_o,
  output logic              line_rep_o,
  output logic              pix_adv_o,
  output logic              vblank_o,
  output logic [23:0]       border_rgb_o,
  output logic              pix_clk_dbl_o
);
  cfg_t act;
  logic xfer, vblank;

  assign xfer = !act.en || vblank;

  rtg_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .xfer_i (xfer),
    .act_o  (act)
  );

  rtg_counters u_cnt (
    .clk_i, .rst_ni,
    .cfg_i   (act),
    .h_o     (hcnt_o),
    .v_o     (vcnt_o),
    .field_o (field_o),
    .rep_o   (line_rep_o)
  );

  rtg_decode #(.HSYNC_W(HSYNC_W), .VSYNC_L(VSYNC_L)) u_dec (
    .clk_i, .rst_ni,
    .cfg_i     (act),
    .h_i       (hcnt_o),
    .v_i       (vcnt_o),
    .rep_i     (line_rep_o),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .border_o  (border_o),
    .window_o  (window_o),
    .pix_adv_o (pix_adv_o),
    .vblank_o  (vblank)
  );

  assign vblank_o      = vblank;
  assign border_rgb_o  = act.rgb;
  assign pix_clk_dbl_o = act.clkdbl;
endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  import rtg_pkg::*;

  localparam int HSW = 6;
  localparam int VSL = 2;
  localparam longint TIMEOUT_NS = 64'd1_990_000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [9:0] hcnt_o, vcnt_o;
  logic hsync_o, vsync_o, border_o, window_o, field_o, line_rep_o, pix_adv_o, vblank_o;
  logic [23:0] border_rgb_o;
  logic pix_clk_dbl_o;

  always #5 clk_i = ~clk_i;

  raster_timing_gen #(.HSYNC_W(HSW), .VSYNC_L(VSL)) u_raster_timing_gen (.*);

  int n_chk = 0, n_fail = 0, n_vb = 0;
  bit done = 0;
  cfg_t m_sh, m_act;
  logic [9:0] mh, mv;
  bit mf, mr;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      if (n_fail <= 30) $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic cfg_t wr(cfg_t c, logic [2:0] a, logic [31:0] d);
    case (a)
      3'd0: begin c.htot = d[9:0];  c.vtot = d[25:16]; end
      3'd1: begin c.bsh  = d[25:16]; c.beh = d[9:0]; end
      3'd2: begin c.bsv  = d[25:16]; c.bev = d[9:0]; end
      3'd3: begin c.wh   = d[9:0];  c.wv   = d[25:16]; end
      3'd4: begin c.en = d[0]; c.ldbl = d[1]; c.clkdbl = d[23]; end
      3'd5: begin c.pdbl = d[0]; c.blank = d[3]; end
      3'd6: begin c.vid = d[8]; c.il = d[4]; end
      default: c.rgb = d[23:0];
    endcase
    return c;
  endfunction

  function automatic bit exp_vb();
    return m_act.en && mh == 0 && mv == m_act.bev && !mr;
  endfunction

  task automatic check_outputs();
    bit oe, vis, win, ew, eb;
    logic [9:0] rel;
    string rt;
    oe  = m_act.en && m_act.vid;
    vis = mh >= m_act.bsh && mh < m_act.beh && mv >= m_act.bsv && mv < m_act.bev;
    win = vis && mh >= m_act.wh && mv >= m_act.wv;
    ew  = oe && win && !m_act.blank;
    eb  = oe && vis && (m_act.blank || !win);
    rel = mh - m_act.wh;
    rt  = !oe ? "R11" : (m_act.blank ? "R9" : "R8");
    chk(m_act.en ? "R3" : "R11", "hcnt", hcnt_o, mh);
    chk(m_act.ldbl ? "R6" : "R4", "vcnt", vcnt_o, mv);
    chk("R5", "field", field_o, mf);
    chk("R6", "line_rep", line_rep_o, mr);
    chk(oe ? "R7" : "R11", "hsync", hsync_o, oe && mh < HSW);
    chk(oe ? "R7" : "R11", "vsync", vsync_o, oe && mv < VSL);
    chk(rt, "window", window_o, ew);
    chk(rt, "border", border_o, eb);
    chk("R10", "pix_adv", pix_adv_o, ew && (!m_act.pdbl || !rel[0]));
    chk("R4", "vblank", vblank_o, exp_vb());
    chk("R12", "rgb", border_rgb_o, m_act.rgb);
    chk("R12", "clkdbl", pix_clk_dbl_o, m_act.clkdbl);
  endtask

  task automatic model_step(input bit we, input logic [2:0] a, input logic [31:0] d);
    cfg_t c;
    bit vb, xf;
    logic [9:0] lastv;
    c = m_act;
    vb = exp_vb();
    xf = !c.en || vb;
    if (!c.en) begin
      mh = 0; mv = 0; mf = 0; mr = 0;
    end else if (mh != c.htot) begin
      mh = mh + 1'b1;
    end else begin
      mh = 0;
      if (c.ldbl && !mr) mr = 1;
      else begin
        mr = 0;
        lastv = (c.il && mf) ? c.vtot - 1'b1 : c.vtot;
        if (mv == lastv) begin mv = 0; mf = c.il ? !mf : 1'b0; end
        else mv = mv + 1'b1;
      end
    end
    if (xf) m_act = m_sh;
    if (we) m_sh = wr(m_sh, a, d);
    if (vb) n_vb++;
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic cyc(input bit we, input logic [2:0] a, input logic [31:0] d);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    check_outputs();
    @(posedge clk_i);
    model_step(we, a, d);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 3'd0, 32'd0);
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic stop_display();
    cyc(1, 3'd4, 32'd0);
    for (int i = 0; i < 6000 && m_act.en; i++) cyc(0, 3'd0, 32'd0);
  endtask

  task automatic load_cfg(input int ht, vt, bsh, beh, bsv, bev, wh, wv,
                          input bit ldbl, clkd, pdbl, blank, vid, il, input logic [23:0] rgb);
    cyc(1, 3'd0, (32'(vt) << 16) | 32'(ht));
    cyc(1, 3'd1, (32'(bsh) << 16) | 32'(beh));
    cyc(1, 3'd2, (32'(bsv) << 16) | 32'(bev));
    cyc(1, 3'd3, (32'(wv) << 16) | 32'(wh));
    cyc(1, 3'd5, (32'(blank) << 3) | 32'(pdbl));
    cyc(1, 3'd6, (32'(vid) << 8) | (32'(il) << 4));
    cyc(1, 3'd7, {8'h0, rgb});
    cyc(1, 3'd4, (32'(clkd) << 23) | (32'(ldbl) << 1) | 32'd1);
  endtask

  task automatic run_frames(input int nf);
    int start;
    start = n_vb;
    for (int i = 0; i < 8000 && (n_vb - start) < nf; i++) cyc(0, 3'd0, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    m_sh = '0; m_act = '0; mh = 0; mv = 0; mf = 0; mr = 0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "hcnt", hcnt_o, 0);
    chk("R1", "vcnt", vcnt_o, 0);
    chk("R1", "flags", {hsync_o, vsync_o, border_o, window_o, field_o, line_rep_o, pix_adv_o, vblank_o}, 0);
    chk("R1", "rgb", border_rgb_o, 0);
    chk("R1", "clkdbl", pix_clk_dbl_o, 0);
    rst_ni = 1'b1;
    idle(3);

    // directed: plain progressive, then interlaced, then blank with line doubling
    load_cfg(31, 15, 2, 28, 1, 13, 5, 3, 0, 0, 0, 0, 1, 0, 24'h123456);
    run_frames(2);
    stop_display();
    load_cfg(27, 13, 1, 25, 1, 12, 4, 2, 0, 1, 1, 0, 1, 1, 24'hA0B0C0);
    run_frames(4);

    // R2: a colour written mid-frame stays hidden until the vblank transfer
    begin
      logic [23:0] old_c;
      int start;
      old_c = m_act.rgb;
      cyc(1, 3'd7, 32'h00_55AA33);
      start = n_vb;
      for (int i = 0; i < 3000 && n_vb == start; i++) begin
        chk("R2", "rgb held", border_rgb_o, old_c);
        cyc(0, 3'd0, 32'd0);
      end
      chk("R2", "rgb moved", border_rgb_o, 24'h55AA33);
    end

    stop_display();
    load_cfg(25, 12, 0, 24, 0, 11, 3, 2, 1, 0, 1, 1, 1, 0, 24'h0F0F0F);
    run_frames(2);
    stop_display();
    // R11: video disabled while counters run
    load_cfg(25, 12, 0, 24, 0, 11, 3, 2, 0, 0, 0, 0, 0, 0, 24'h010203);
    run_frames(1);
    stop_display();

    // random configurations
    for (int k = 0; k < 12; k++) begin
      int ht, vt, bsh, beh, bsv, bev;
      ht = rnd(24, 47); vt = rnd(12, 23);
      bsh = rnd(0, 4); beh = rnd(ht - 6, ht - 1);
      bsv = rnd(0, 2); bev = rnd(vt - 4, vt - 1);
      load_cfg(ht, vt, bsh, beh, bsv, bev, rnd(bsh, bsh + 6), rnd(bsv, bsv + 3),
               1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
               ($urandom % 6) != 0, 1'($urandom), 24'($urandom));
      if ((k % 3) == 1) cyc(1, 3'd5, {28'd0, 1'b1, 3'd0});
      run_frames(2);
      stop_display();
    end

    // R3: 60 Hz broadcast totals, two full lines and a bit
    load_cfg(857, 262, 10, 850, 2, 250, 20, 5, 0, 0, 0, 0, 1, 1, 24'hFFFFFF);
    idle(2 * 858 + 6);
    chk("R3", "broadcast line count", vcnt_o, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(TIMEOUT_NS);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule